// File: doc/BRIEF.md
# Rectangle Fill Engine

This block paints one solid rectangle into a 1280-pixel-wide linear framebuffer. When started, it reads a short command packet through a packet-memory read port. The packet holds an opcode word, a line-width word, a colour attribute word and two packed corner vertices. The block checks the opcode and removes the line-width bias from both vertices. It then decodes the corner coordinates, turns the attribute into a pixel value for the selected colour depth, and writes the rectangle one pixel per cycle through a framebuffer write port.

While it runs, the block keeps a dirty rectangle. This is the bounding box of every column corner and every row it has touched since reset. A display refresh path can then limit its copy to that region. Control is a start/busy/done handshake. The colour depth is taken from `mode24` at the moment a start is accepted.

Top module: `rect_fill`

## Requirements
- R1: A `start` pulse seen while both `busy` and `done` are low is accepted, and `busy` is high on the next cycle. `done` is a single-cycle pulse with `busy` low. A `start` that arrives while `busy` is high has no effect on the run in progress: no extra pixels are written and no extra `done` is given.
- R2: Packet word 0 must equal 0x411. Any other value ends the run with a `done` pulse, no framebuffer write, no further packet read and no change to the dirty rectangle.
- R3: A valid packet is read at word indices 0, 4, 5, 6, 7, in that order. Word 4 is the raw line width, word 5 the attribute, word 6 the first corner and word 7 the second corner. Read data is returned one cycle after `pkt_rd`.
- R4: The raw line width is subtracted, modulo 2^32, from each corner word. In the result, x is bits 29:19 (11 bits) and y is bits 12:3 (10 bits).
- R5: The effective line width is (raw + 1) >> 2. The rows filled are y1 up to y2 + effective width − 1, inclusive. No row is filled when that end lies below y1.
- R6: The fill width is x2 − x1, capped at 1280. It is zero, and nothing is written, when x2 ≤ x1. The columns written are x1 to x1 + width − 1.
- R7: In 24-bit mode (`mode24`=1), attribute bits 23:16 select a grey level: 0 gives 0x00, 7 gives 0xC0, and any other value gives 0xFF. The pixel carries that level in all three bytes.
- R8: In 8-bit mode (`mode24`=0), every pixel is the attribute's bits 7:0 in `fb_wdata[7:0]`, with bits 23:8 zero.
- R9: Pixels are written row-major in consecutive cycles at address row*1280 + column. `done` follows in the cycle after the last write.
- R10: Out of reset the dirty rectangle is empty: x low 2047, x high 0, y low 0xFFFFFFFF, y high 0. Every packet with a valid opcode widens x low to at most x1 and x high to at least x2 (decoded, before the cap), even when no pixel is written.
- R11: Every row that receives pixels widens y low and y high to include that row. Rows that receive no pixels leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet |
| mode24 | input | 1 | 1: 24-bit grey pixels, 0: 8-bit pixels; sampled at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pkt_rd | output | 1 | Packet read request |
| pkt_addr | output | 3 | Packet word index |
| pkt_rdata | input | 32 | Packet word, valid one cycle after the request |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_addr | output | 32 | Linear pixel address |
| fb_wdata | output | 24 | Pixel value |
| dirty_x_lo | output | 11 | Dirty rectangle left column |
| dirty_x_hi | output | 11 | Dirty rectangle right column |
| dirty_y_lo | output | 32 | Dirty rectangle top row |
| dirty_y_hi | output | 32 | Dirty rectangle bottom row |

## Verification
The bench builds the block with its default parameters: a 1280-pixel row, 11-bit columns and 32-bit row counters. With these values the width cap is reached by a corner pair whose difference exceeds 1280, so a full capped row of 1280 writes is compared pixel by pixel. Row counters this wide also let the line-width extension run past the 10-bit vertex range without wrapping. A line width of 13 makes the bias subtraction borrow into the y field, so decoding after the subtraction gives a different answer from decoding before it.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam logic [31:0] FILL_OPCODE = 32'h0000_0411;
  localparam int VX_LSB = 19;
  localparam int VX_W   = 11;
  localparam int VY_LSB = 3;
  localparam int VY_W   = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_CAP, ST_SETUP, ST_FILL, ST_DONE
  } rf_state_e;

  // column field of an unbiased corner
  function automatic logic [VX_W-1:0] corner_x(input logic [31:0] v, input logic [31:0] bias);
    logic [31:0] t;
    t = v - bias;
    return t[VX_LSB +: VX_W];
  endfunction

  // row field of an unbiased corner
  function automatic logic [VY_W-1:0] corner_y(input logic [31:0] v, input logic [31:0] bias);
    logic [31:0] t;
    t = v - bias;
    return t[VY_LSB +: VY_W];
  endfunction

  // rounded quarter of the raw line width
  function automatic logic [31:0] eff_width(input logic [31:0] raw);
    logic [32:0] s;
    s = {1'b0, raw} + 33'd1;
    return 32'(s >> 2);
  endfunction

  function automatic logic [7:0] grey_level(input logic [7:0] sel);
    if (sel == 8'd0)      return 8'h00;
    else if (sel == 8'd7) return 8'hC0;
    else                  return 8'hFF;
  endfunction

  function automatic logic [23:0] pixel_of(input logic [31:0] attr, input logic deep);
    logic [7:0] g;
    g = grey_level(attr[23:16]);
    if (deep) return {g, g, g};
    else      return {16'h0000, attr[7:0]};
  endfunction
endpackage

// File: rtl/rf_decode.sv
module rf_decode import rf_pkg::*; #(
  parameter int FB_W  = 1280,
  parameter int ROW_W = 32,
  parameter int WID_W = $clog2(FB_W + 1)
) (
  input  logic [31:0]      lw_raw,
  input  logic [31:0]      attr,
  input  logic [31:0]      v_a,
  input  logic [31:0]      v_b,
  input  logic             deep,
  output logic [VX_W-1:0]  x_a,
  output logic [VX_W-1:0]  x_b,
  output logic [ROW_W-1:0] y_first,
  output logic [ROW_W-1:0] y_stop,
  output logic [WID_W-1:0] width,
  output logic [23:0]      pixel,
  output logic             empty
);
  localparam int DW = VX_W + 2;
  logic signed [DW-1:0] diff;
  logic [VY_W-1:0] ya, yb;

  always_comb begin
    x_a     = corner_x(v_a, lw_raw);
    x_b     = corner_x(v_b, lw_raw);
    ya      = corner_y(v_a, lw_raw);
    yb      = corner_y(v_b, lw_raw);
    y_first = ROW_W'(ya);
    y_stop  = ROW_W'(yb) + ROW_W'(eff_width(lw_raw));
    diff    = $signed({2'b00, x_b}) - $signed({2'b00, x_a});
    if (diff <= 0)                   width = '0;
    else if (int'(diff) > FB_W)      width = WID_W'(FB_W);
    else                             width = WID_W'(diff);
    pixel   = pixel_of(attr, deep);
    empty   = (width == '0) || (y_stop <= y_first);
  end
endmodule

// File: rtl/rf_raster.sv
module rf_raster #(
  parameter int FB_W  = 1280,
  parameter int COL_W = 12,
  parameter int ROW_W = 32,
  parameter int WID_W = 11,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] x0,
  input  logic [WID_W-1:0] width,
  input  logic [ROW_W-1:0] y0,
  input  logic [ROW_W-1:0] y_stop,
  output logic             we,
  output logic [AW-1:0]    addr,
  output logic [ROW_W-1:0] row,
  output logic             last
);
  logic [COL_W-1:0] col, col_start, col_last;
  logic [ROW_W-1:0] row_last;
  logic             active, row_end;

  assign row_end = (col == col_last);
  assign last    = active && row_end && (row == row_last);
  assign we      = active;
  assign addr    = AW'(row) * AW'(FB_W) + AW'(col);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      col       <= '0;
      col_start <= '0;
      col_last  <= '0;
      row       <= '0;
      row_last  <= '0;
    end else if (load) begin
      active    <= 1'b1;
      col       <= x0;
      col_start <= x0;
      col_last  <= x0 + COL_W'(width) - COL_W'(1);
      row       <= y0;
      row_last  <= y_stop - ROW_W'(1);
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
      end else if (row_end) begin
        col <= col_start;
        row <= row + ROW_W'(1);
      end else begin
        col <= col + COL_W'(1);
      end
    end
  end

  // R9: within a row the address advances by one pixel per cycle
  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && $past(we) && row == $past(row)) |-> addr == $past(addr) + AW'(1));
  // R9: a new row is exactly the next one
  p_row_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && $past(we) && row != $past(row)) |-> row == $past(row) + ROW_W'(1));
endmodule

// File: rtl/rf_dirty.sv
module rf_dirty import rf_pkg::*; #(
  parameter int ROW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_x,
  input  logic [VX_W-1:0]  x_a,
  input  logic [VX_W-1:0]  x_b,
  input  logic             upd_y,
  input  logic [ROW_W-1:0] row,
  output logic [VX_W-1:0]  x_lo,
  output logic [VX_W-1:0]  x_hi,
  output logic [ROW_W-1:0] y_lo,
  output logic [ROW_W-1:0] y_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_lo <= '1;
      x_hi <= '0;
      y_lo <= '1;
      y_hi <= '0;
    end else begin
      if (upd_x) begin
        if (x_a < x_lo) x_lo <= x_a;
        if (x_b > x_hi) x_hi <= x_b;
      end
      if (upd_y) begin
        if (row < y_lo) y_lo <= row;
        if (row > y_hi) y_hi <= row;
      end
    end
  end

  // R10: the column bounds only ever widen
  p_x_grow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (x_lo <= $past(x_lo)) && (x_hi >= $past(x_hi)));
  // R11: a written row lies inside the row bounds afterwards
  p_y_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_y |=> (y_lo <= $past(row)) && (y_hi >= $past(row)));
endmodule

// File: rtl/rect_fill.sv
module rect_fill import rf_pkg::*; #(
  parameter int FB_W  = 1280,
  parameter int ROW_W = 32,
  parameter int AW    = 32,
  parameter int PKT_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode24,
  output logic              busy,
  output logic              done,
  output logic              pkt_rd,
  output logic [PKT_AW-1:0] pkt_addr,
  input  logic [31:0]       pkt_rdata,
  output logic              fb_we,
  output logic [AW-1:0]     fb_addr,
  output logic [23:0]       fb_wdata,
  output logic [VX_W-1:0]   dirty_x_lo,
  output logic [VX_W-1:0]   dirty_x_hi,
  output logic [ROW_W-1:0]  dirty_y_lo,
  output logic [ROW_W-1:0]  dirty_y_hi
);
  localparam int WID_W  = $clog2(FB_W + 1);
  localparam int COL_W  = VX_W + 1;
  localparam int NWORDS = 5;
  localparam int KW     = $clog2(NWORDS);

  rf_state_e        st;
  logic [KW-1:0]    k;
  logic [31:0]      w_lw, w_attr, w_va, w_vb;
  logic             deep;

  logic [VX_W-1:0]  d_xa, d_xb;
  logic [ROW_W-1:0] d_y0, d_ystop, r_row;
  logic [WID_W-1:0] d_width;
  logic             d_empty, r_last;
  logic             accept, bad_opcode, fill_load, x_update;

  assign accept     = (st == ST_IDLE) && start;
  assign bad_opcode = (st == ST_CAP) && (k == '0) && (pkt_rdata != FILL_OPCODE);
  assign fill_load  = (st == ST_SETUP) && !d_empty;
  assign x_update   = (st == ST_SETUP);
  assign busy       = (st != ST_IDLE) && (st != ST_DONE);
  assign done       = (st == ST_DONE);
  assign pkt_rd     = (st == ST_REQ);
  // word 0 first, then the four consecutive words from index 4
  assign pkt_addr   = (k == '0) ? PKT_AW'(0) : PKT_AW'(k) + PKT_AW'(3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      k      <= '0;
      deep   <= 1'b0;
      w_lw   <= '0;
      w_attr <= '0;
      w_va   <= '0;
      w_vb   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_REQ;
          k    <= '0;
          deep <= mode24;
        end
        ST_REQ: st <= ST_CAP;
        ST_CAP: begin
          case (k)
            KW'(1): w_lw   <= pkt_rdata;
            KW'(2): w_attr <= pkt_rdata;
            KW'(3): w_va   <= pkt_rdata;
            KW'(4): w_vb   <= pkt_rdata;
            default: ;
          endcase
          if (bad_opcode)                st <= ST_DONE;
          else if (k == KW'(NWORDS - 1)) st <= ST_SETUP;
          else begin
            k  <= k + KW'(1);
            st <= ST_REQ;
          end
        end
        ST_SETUP: st <= d_empty ? ST_DONE : ST_FILL;
        ST_FILL:  if (r_last) st <= ST_DONE;
        ST_DONE:  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  rf_decode #(.FB_W(FB_W), .ROW_W(ROW_W), .WID_W(WID_W)) u_dec (
    .lw_raw(w_lw), .attr(w_attr), .v_a(w_va), .v_b(w_vb), .deep(deep),
    .x_a(d_xa), .x_b(d_xb), .y_first(d_y0), .y_stop(d_ystop),
    .width(d_width), .pixel(fb_wdata), .empty(d_empty)
  );

  rf_raster #(.FB_W(FB_W), .COL_W(COL_W), .ROW_W(ROW_W), .WID_W(WID_W), .AW(AW)) u_ras (
    .clk(clk), .rst_n(rst_n), .load(fill_load), .x0(COL_W'(d_xa)),
    .width(d_width), .y0(d_y0), .y_stop(d_ystop),
    .we(fb_we), .addr(fb_addr), .row(r_row), .last(r_last)
  );

  rf_dirty #(.ROW_W(ROW_W)) u_dirty (
    .clk(clk), .rst_n(rst_n), .upd_x(x_update), .x_a(d_xa), .x_b(d_xb),
    .upd_y(fb_we), .row(r_row),
    .x_lo(dirty_x_lo), .x_hi(dirty_x_hi), .y_lo(dirty_y_lo), .y_hi(dirty_y_hi)
  );

  // R1: an accepted start raises busy on the next cycle
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R1: done lasts one cycle and never overlaps busy
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);
  // R2: a wrong opcode ends the run at once
  p_bad_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_opcode |=> done && !fb_we);
  // R9: pixels are only written during a run
  p_we_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> busy);
  // R7: the pixel value holds across a run of writes
  p_pixel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && $past(fb_we)) |-> $stable(fb_wdata));
endmodule

// File: tb/rect_fill_test.sv
module rect_fill_test;
  localparam int CLK_PERIOD = 10;
  localparam int FBW = 1280;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode24 = 1'b0;
  logic        busy, done, pkt_rd, fb_we;
  logic [2:0]  pkt_addr;
  logic [31:0] pkt_rdata;
  logic [31:0] fb_addr;
  logic [23:0] fb_wdata;
  logic [10:0] dirty_x_lo, dirty_x_hi;
  logic [31:0] dirty_y_lo, dirty_y_hi;

  logic [31:0] pmem [8];
  logic [55:0] expq [$];
  int          rdlog [$];
  int checks = 0, fails = 0, cyc = 0;
  int nwr = 0, first_wr = -1, last_wr = -1;
  string tag = "R9";
  logic [10:0] ex_xlo = 11'h7FF, ex_xhi = 11'h000;
  logic [31:0] ex_ylo = 32'hFFFF_FFFF, ex_yhi = 32'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rect_fill uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode24(mode24),
    .busy(busy), .done(done), .pkt_rd(pkt_rd), .pkt_addr(pkt_addr),
    .pkt_rdata(pkt_rdata), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .dirty_x_lo(dirty_x_lo), .dirty_x_hi(dirty_x_hi),
    .dirty_y_lo(dirty_y_lo), .dirty_y_hi(dirty_y_hi)
  );

  always_ff @(posedge clk) begin
    if (pkt_rd) pkt_rdata <= pmem[pkt_addr];
    cyc <= cyc + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares each write against the scoreboard
  always @(negedge clk) begin
    if (rst_n && pkt_rd) rdlog.push_back(int'(pkt_addr));
    if (rst_n && fb_we) begin
      nwr++;
      if (first_wr < 0) first_wr = cyc;
      last_wr = cyc;
      if (expq.size() == 0) check({tag, " extra write"}, {fb_addr, fb_wdata}, 64'h0);
      else begin
        logic [55:0] e;
        e = expq.pop_front();
        check(tag, {8'h0, fb_addr, fb_wdata}, {8'h0, e});
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] enc(input int x, input int y, input logic [31:0] lw);
    return ((32'(x) << 19) | (32'(y) << 3)) + lw;
  endfunction

  function automatic logic [23:0] exp_pix(input logic [31:0] attr, input bit m24);
    logic [7:0] g;
    if (!m24) return {16'h0, attr[7:0]};
    case (attr[23:16])
      8'd0: g = 8'h00;
      8'd7: g = 8'hC0;
      default: g = 8'hFF;
    endcase
    return {g, g, g};
  endfunction

  task automatic run(input string t, input logic [31:0] op, input logic [31:0] lw,
                     input logic [31:0] attr, input logic [31:0] va, input logic [31:0] vb,
                     input bit m24, input bit poke);
    int nexp = 0, donec;
    tag = t;
    pmem[0] = op; pmem[1] = 32'hDEAD0001; pmem[2] = 32'hDEAD0002; pmem[3] = 32'hDEAD0003;
    pmem[4] = lw; pmem[5] = attr; pmem[6] = va; pmem[7] = vb;
    if (op == 32'h411) begin
      int x1, x2, y1, w, diff;
      longint yend;
      logic [31:0] a, b;
      a = va - lw; b = vb - lw;
      x1 = int'(a[29:19]); x2 = int'(b[29:19]); y1 = int'(a[12:3]);
      yend = longint'(b[12:3]) + longint'((33'(lw) + 33'd1) >> 2);
      diff = x2 - x1;
      w = (diff <= 0) ? 0 : (diff > FBW ? FBW : diff);
      if (11'(x1) < ex_xlo) ex_xlo = 11'(x1);
      if (11'(x2) > ex_xhi) ex_xhi = 11'(x2);
      if (w > 0)
        for (longint r = y1; r < yend; r++) begin
          for (int c = x1; c < x1 + w; c++) begin
            expq.push_back({32'(r * FBW + c), exp_pix(attr, m24)});
            nexp++;
          end
          if (32'(r) < ex_ylo) ex_ylo = 32'(r);
          if (32'(r) > ex_yhi) ex_yhi = 32'(r);
        end
    end
    rdlog.delete(); nwr = 0; first_wr = -1; last_wr = -1;
    @(negedge clk); mode24 = m24; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({t, " R1 busy after start"}, 64'(busy), 64'd1);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    donec = cyc;
    check({t, " R1 busy low with done"}, 64'(busy), 64'd0);
    check({t, " R9 write count"}, 64'(nwr), 64'(nexp));
    check({t, " R9 queue drained"}, 64'(expq.size()), 64'd0);
    if (nexp > 0) begin
      check({t, " R9 back-to-back"}, 64'(last_wr - first_wr + 1), 64'(nexp));
      check({t, " R9 done after last"}, 64'(donec), 64'(last_wr + 1));
    end
    if (op == 32'h411) begin
      check({t, " R3 reads"}, 64'(rdlog.size()), 64'd5);
      if (rdlog.size() == 5)
        check({t, " R3 order"}, {rdlog[0][7:0], rdlog[1][7:0], rdlog[2][7:0], rdlog[3][7:0], rdlog[4][7:0]},
              {8'd0, 8'd4, 8'd5, 8'd6, 8'd7});
    end else begin
      check({t, " R2 reads"}, 64'(rdlog.size()), 64'd1);
    end
    check({t, " R10 dirty x lo"}, 64'(dirty_x_lo), 64'(ex_xlo));
    check({t, " R10 dirty x hi"}, 64'(dirty_x_hi), 64'(ex_xhi));
    check({t, " R11 dirty y lo"}, 64'(dirty_y_lo), 64'(ex_ylo));
    check({t, " R11 dirty y hi"}, 64'(dirty_y_hi), 64'(ex_yhi));
    @(negedge clk);
    check({t, " R1 done one cycle"}, 64'(done), 64'd0);
    check({t, " R1 idle after run"}, 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R1 reset busy", 64'(busy), 64'd0);
    check("R1 reset done", 64'(done), 64'd0);
    check("R9 reset we", 64'(fb_we), 64'd0);
    check("R10 reset x lo", 64'(dirty_x_lo), 64'h7FF);
    check("R10 reset x hi", 64'(dirty_x_hi), 64'h0);
    check("R11 reset y lo", 64'(dirty_y_lo), 64'hFFFF_FFFF);
    check("R11 reset y hi", 64'(dirty_y_hi), 64'h0);
    // R6/R10: x2 below x1, no pixels, dirty x still widens
    run("R6 empty", 32'h411, 32'd3, 32'h0, enc(50, 4, 3), enc(40, 6, 3), 1'b0, 1'b0);
    // R5: no rows when end lies below start
    run("R5 no rows", 32'h411, 32'd0, 32'h0, enc(60, 9, 0), enc(70, 9, 0), 1'b0, 1'b0);
    // R2: wrong opcode
    run("R2 bad op", 32'h412, 32'd3, 32'h0, enc(0, 0, 3), enc(900, 100, 3), 1'b0, 1'b0);
    // R8/R4/R5: 8-bit, lw eff 1
    run("R8 8bit", 32'h411, 32'd3, 32'h00C3_12AB, enc(10, 5, 3), enc(14, 6, 3), 1'b0, 1'b0);
    // R7: grey 7 -> C0, lw eff 0
    run("R7 grey7", 32'h411, 32'd0, 32'h0007_0000, enc(100, 2, 0), enc(103, 4, 0), 1'b1, 1'b0);
    // R7: grey 0 -> 00
    run("R7 grey0", 32'h411, 32'd6, 32'h0000_00FF, enc(200, 20, 6), enc(203, 20, 6), 1'b1, 1'b0);
    // R7: grey other -> FF
    run("R7 grey5", 32'h411, 32'd6, 32'h0005_0000, enc(300, 30, 6), enc(302, 31, 6), 1'b1, 1'b0);
    // R4: bias of 13 borrows into the y field, lw eff 3
    run("R4 bias", 32'h411, 32'd13, 32'h0000_0055, enc(1, 7, 13), enc(3, 7, 13), 1'b0, 1'b0);
    // R6 cap with R1 start poked mid-run
    run("R6 cap", 32'h411, 32'd3, 32'h0001_0000, enc(5, 1, 3), enc(2000, 1, 3), 1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule